// File: doc/BRIEF.md
# UART Status and Interrupt Event Controller

This block sits beside a UART receiver and transmitter and turns their raw conditions into status flags and one interrupt request. It watches the receive FIFO fill level, the clear-to-send input and the transmitter-empty indication. Software reaches it through a simple register write port. A receive flag follows the FIFO level against a threshold of two or four words, chosen by a configuration bit. Two sticky flags record that clear-to-send was reasserted and that a transmitted byte has finished.

Software clears a sticky flag by writing a one to its bit. The interrupt enable bits have separate set and clear addresses, so one enable can change without disturbing the others. The interrupt request is the registered OR of every flag whose enable bit is set.

Register addresses (wr_addr): 0 = configuration (wr_data bit 0 selects the deep threshold), 1 = status clear (write ones to clear), 2 = enable set, 3 = enable clear. Status and enable bit positions: bit 0 = receive threshold, bit 1 = clear-to-send reasserted, bit 2 = transmit finished.

Top module: `uart_event_ctl`

## Requirements
- R1: After reset, status, mask, cfg_deep and irq are all 0.
- R2: The receive flag (status bit 0) equals, one cycle later, whether rx_level is at least the threshold: 2 words when cfg_deep is 0, and 4 words when it is 1. A write to address 0 sets cfg_deep from wr_data bit 0.
- R3: The receive flag drops by itself once rx_level falls below the selected threshold. A one written to status bit 0 through address 1 has no effect on it.
- R4: Status bit 1 becomes 1 one cycle after cts_in goes from 0 to 1 (cts_in = 1 means asserted). It stays 1 when cts_in falls again. cts_in held high out of reset does not set it.
- R5: Writing a 1 in data bit 1 to address 1 clears status bit 1 on the next cycle.
- R6: Status bit 2 becomes 1 one cycle after tx_empty goes from 0 to 1, but only if tx_load was 1 in some earlier cycle since reset.
- R7: Writing a 1 in data bit 2 to address 1 clears status bit 2 on the next cycle.
- R8: Writing 0 to a status bit leaves it unchanged. If a set event and a clear write hit the same bit in the same cycle, the bit ends up 1.
- R9: A write to address 2 sets the mask bits where wr_data is 1. A write to address 3 clears them. Mask bits where wr_data is 0 keep their value.
- R10: irq equals, one cycle later, the OR over all bits of status AND mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_level | input | LVL_W (4) | Receive FIFO fill level in words |
| cts_in | input | 1 | Clear-to-send, 1 = asserted |
| tx_load | input | 1 | A byte entered the transmitter this cycle |
| tx_empty | input | 1 | Transmitter is idle and empty |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (2) | Register address |
| wr_data | input | DATA_W (8) | Register write data |
| status | output | 3 | Status flags {tx finished, cts reasserted, rx threshold} |
| mask | output | 3 | Interrupt enable bits, same positions as status |
| cfg_deep | output | 1 | 1 selects the four-word receive threshold |
| irq | output | 1 | Registered status interrupt request |

## Verification
Every flag, the mask and cfg_deep change on the first clock edge after the input or write that causes them. irq changes one edge after that, which is two edges after the original stimulus. The bench drives inputs on the falling edge and keeps a behavioural model that steps on each rising edge. It compares every output on the next falling edge. Directed checks wait exactly one edge before looking at flags and mask, and two edges before looking at irq, so each value is checked in the cycle it becomes due.

// File: rtl/uart_evt_pkg.sv
package uart_evt_pkg;

  // status / mask bit positions
  localparam int ST_RX  = 0;
  localparam int ST_CTS = 1;
  localparam int ST_TXD = 2;
  localparam int ST_W   = 3;

  // register addresses
  localparam int ADR_CFG  = 0;
  localparam int ADR_STAT = 1;
  localparam int ADR_MSET = 2;
  localparam int ADR_MCLR = 3;

  // which status bits are sticky (others follow a level)
  localparam logic [ST_W-1:0] STICKY_SEL = 3'b110;

  function automatic int unsigned thr_words(logic deep, int unsigned lo, int unsigned hi);
    return deep ? hi : lo;
  endfunction

  function automatic logic level_meets(int unsigned lvl, int unsigned thr);
    return lvl >= thr;
  endfunction

  // set has priority over a clear request
  function automatic logic sticky_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/uevt_regif.sv
module uevt_regif
  import uart_evt_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              cfg_deep,
  output logic [ST_W-1:0]   mask,
  output logic [ST_W-1:0]   w1c_req
);

  logic hit_cfg, hit_stat, hit_mset, hit_mclr;
  logic [ST_W-1:0] bits;
  logic unused_data;

  assign bits        = wr_data[ST_W-1:0];
  assign unused_data = ^wr_data[DATA_W-1:ST_W];

  assign hit_cfg  = wr_en && (wr_addr == ADDR_W'(ADR_CFG));
  assign hit_stat = wr_en && (wr_addr == ADDR_W'(ADR_STAT));
  assign hit_mset = wr_en && (wr_addr == ADDR_W'(ADR_MSET));
  assign hit_mclr = wr_en && (wr_addr == ADDR_W'(ADR_MCLR));

  assign w1c_req = hit_stat ? bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_deep <= 1'b0;
      mask     <= '0;
    end else begin
      if (hit_cfg)  cfg_deep <= wr_data[0];
      if (hit_mset) mask     <= mask | bits;
      else if (hit_mclr) mask <= mask & ~bits;
    end
  end

endmodule

// File: rtl/uevt_edge.sv
module uevt_edge #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic rise
);

  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= sig;
  end

  assign rise = sig & ~prev;

endmodule

// File: rtl/uevt_stat_bit.sv
module uevt_stat_bit
  import uart_evt_pkg::*;
#(
  parameter bit STICKY = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic level_in,
  input  logic clr,
  output logic q
);

  generate
    if (STICKY) begin : g_sticky
      logic unused_lvl;
      assign unused_lvl = level_in;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= sticky_next(q, set_evt, clr);
      end
    end else begin : g_level
      logic unused_ctl;
      assign unused_ctl = set_evt ^ clr;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= level_in;
      end
    end
  endgenerate

endmodule

// File: rtl/uart_event_ctl.sv
module uart_event_ctl
  import uart_evt_pkg::*;
#(
  parameter int LVL_W  = 4,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter int THR_LO = 2,
  parameter int THR_HI = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              cts_in,
  input  logic              tx_load,
  input  logic              tx_empty,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [ST_W-1:0]   status,
  output logic [ST_W-1:0]   mask,
  output logic              cfg_deep,
  output logic              irq
);

  // named internal events (observed by the checker)
  logic [ST_W-1:0] w1c_req;
  logic            cts_rise;
  logic            txe_rise;
  logic            tx_armed;
  logic            tx_fin_evt;
  logic            rx_meet;
  logic [ST_W-1:0] ev_set;
  logic [ST_W-1:0] ev_lvl;

  uevt_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg_deep(cfg_deep), .mask(mask), .w1c_req(w1c_req)
  );

  uevt_edge #(.RST_VAL(1'b1)) u_cts_edge (
    .clk(clk), .rst_n(rst_n), .sig(cts_in), .rise(cts_rise)
  );

  uevt_edge #(.RST_VAL(1'b1)) u_txe_edge (
    .clk(clk), .rst_n(rst_n), .sig(tx_empty), .rise(txe_rise)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tx_armed <= 1'b0;
    else if (tx_load) tx_armed <= 1'b1;
  end

  assign tx_fin_evt = txe_rise & tx_armed;
  assign rx_meet    = level_meets(int'(rx_level), thr_words(cfg_deep, THR_LO, THR_HI));

  always_comb begin
    ev_set         = '0;
    ev_lvl         = '0;
    ev_set[ST_CTS] = cts_rise;
    ev_set[ST_TXD] = tx_fin_evt;
    ev_lvl[ST_RX]  = rx_meet;
  end

  for (genvar i = 0; i < ST_W; i++) begin : g_stat
    uevt_stat_bit #(.STICKY(STICKY_SEL[i])) u_bit (
      .clk(clk), .rst_n(rst_n), .set_evt(ev_set[i]), .level_in(ev_lvl[i]),
      .clr(w1c_req[i]), .q(status[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(status & mask);
  end

endmodule

// File: rtl/uevt_checker.sv
module uevt_checker
  import uart_evt_pkg::*;
#(
  parameter int LVL_W  = 4,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter int THR_LO = 2,
  parameter int THR_HI = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LVL_W-1:0]  rx_level,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [ST_W-1:0]   status,
  input logic [ST_W-1:0]   mask,
  input logic              cfg_deep,
  input logic              irq,
  input logic [ST_W-1:0]   w1c_req,
  input logic              cts_rise,
  input logic              tx_fin_evt,
  input logic              tx_armed
);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R2 and R3: receive flag tracks level against the selected threshold
  assert_rx_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (status[ST_RX] ==
      (int'($past(rx_level)) >= ($past(cfg_deep) ? THR_HI : THR_LO))));

  assert_cts_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cts_rise |=> status[ST_CTS]);

  assert_cts_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (w1c_req[ST_CTS] && !cts_rise) |=> !status[ST_CTS]);

  assert_txd_armed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $rose(status[ST_TXD])) |-> $past(tx_armed));

  assert_txd_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (w1c_req[ST_TXD] && !tx_fin_evt) |=> !status[ST_TXD]);

  assert_cts_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (status[ST_CTS] && !w1c_req[ST_CTS]) |=> status[ST_CTS]);

  assert_txd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (status[ST_TXD] && !w1c_req[ST_TXD]) |=> status[ST_TXD]);

  assert_mask_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(ADR_MSET)) |=>
      ((mask & $past(wr_data[ST_W-1:0])) == $past(wr_data[ST_W-1:0])));

  assert_mask_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(ADR_MCLR)) |=>
      ((mask & $past(wr_data[ST_W-1:0])) == '0));

  assert_irq_lag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (irq == $past(|(status & mask))));

endmodule

bind uart_event_ctl uevt_checker #(
  .LVL_W(LVL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .THR_LO(THR_LO), .THR_HI(THR_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .status(status), .mask(mask), .cfg_deep(cfg_deep), .irq(irq),
  .w1c_req(w1c_req), .cts_rise(cts_rise), .tx_fin_evt(tx_fin_evt), .tx_armed(tx_armed)
);

// File: tb/uart_event_ctl_bench.sv
module uart_event_ctl_bench;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] rx_level = '0;
  logic       cts_in = 1'b1;
  logic       tx_load = 1'b0;
  logic       tx_empty = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] status, mask;
  logic       cfg_deep, irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  uart_event_ctl u_uart_event_ctl (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .cts_in(cts_in),
    .tx_load(tx_load), .tx_empty(tx_empty), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .status(status), .mask(mask), .cfg_deep(cfg_deep), .irq(irq)
  );

  // behavioural reference model
  bit m_rx, m_cts, m_txd, m_deep, m_irq, m_cts_prev, m_txe_prev, m_armed;
  bit [2:0] m_mask;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rx = 0; m_cts = 0; m_txd = 0; m_deep = 0; m_irq = 0;
      m_mask = 0; m_cts_prev = 1; m_txe_prev = 1; m_armed = 0;
    end else begin
      int  thr;
      bit  clr_cts, clr_txd;
      m_irq = |({m_txd, m_cts, m_rx} & m_mask);
      thr = m_deep ? 4 : 2;
      m_rx = (int'(rx_level) >= thr);
      clr_cts = wr_en && wr_addr == 2'd1 && wr_data[1];
      clr_txd = wr_en && wr_addr == 2'd1 && wr_data[2];
      if (cts_in && !m_cts_prev) m_cts = 1; else if (clr_cts) m_cts = 0;
      if (tx_empty && !m_txe_prev && m_armed) m_txd = 1; else if (clr_txd) m_txd = 0;
      m_cts_prev = cts_in;
      m_txe_prev = tx_empty;
      if (tx_load) m_armed = 1;
      if (wr_en && wr_addr == 2'd0) m_deep = wr_data[0];
      if (wr_en && wr_addr == 2'd2) m_mask = m_mask | wr_data[2:0];
      if (wr_en && wr_addr == 2'd3) m_mask = m_mask & ~wr_data[2:0];
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 R3 model rx",  int'(status[0]), int'(m_rx));
      check("R4 R5 model cts", int'(status[1]), int'(m_cts));
      check("R6 R7 model txd", int'(status[2]), int'(m_txd));
      check("R9 model mask",   int'(mask), int'(m_mask));
      check("R2 model cfg",    int'(cfg_deep), int'(m_deep));
      check("R10 model irq",   int'(irq), int'(m_irq));
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(1);
    wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    check("R1 status", int'(status), 0);
    check("R1 mask", int'(mask), 0);
    check("R1 cfg", int'(cfg_deep), 0);
    check("R1 irq", int'(irq), 0);
    check("R4 cts high from reset", int'(status[1]), 0);

    wr(2'd2, 8'h07);
    check("R9 mask set", int'(mask), 7);

    rx_level = 4'd2; step(1);
    check("R2 shallow at 2", int'(status[0]), 1);
    check("R10 irq not yet", int'(irq), 0);
    step(1);
    check("R10 irq due", int'(irq), 1);

    wr(2'd0, 8'h01); step(1);
    check("R2 deep at 2", int'(status[0]), 0);
    rx_level = 4'd4; step(1);
    check("R2 deep at 4", int'(status[0]), 1);
    rx_level = 4'd3; step(1);
    check("R3 drains below", int'(status[0]), 0);
    rx_level = 4'd4; step(1);
    wr(2'd1, 8'h01);
    check("R3 w1c ignored", int'(status[0]), 1);
    rx_level = 4'd0; step(1);
    check("R3 empty", int'(status[0]), 0);

    cts_in = 1'b0; step(1);
    check("R4 fall no set", int'(status[1]), 0);
    cts_in = 1'b1; step(1);
    check("R4 reassert", int'(status[1]), 1);
    cts_in = 1'b0; step(1);
    check("R4 sticky", int'(status[1]), 1);
    wr(2'd1, 8'h00);
    check("R8 zero write", int'(status[1]), 1);
    wr(2'd1, 8'h02);
    check("R5 w1c cts", int'(status[1]), 0);

    tx_empty = 1'b0; step(1);
    tx_empty = 1'b1; step(1);
    check("R6 unarmed", int'(status[2]), 0);
    tx_load = 1'b1; tx_empty = 1'b0; step(1);
    tx_load = 1'b0; step(1);
    tx_empty = 1'b1; step(1);
    check("R6 finished", int'(status[2]), 1);
    wr(2'd1, 8'h04);
    check("R7 w1c txd", int'(status[2]), 0);

    cts_in = 1'b1;
    wr(2'd1, 8'h02);
    check("R8 set wins", int'(status[1]), 1);

    wr(2'd3, 8'h02);
    check("R9 mask clear", int'(mask), 5);
    step(1);
    check("R10 masked off", int'(irq), 0);
    wr(2'd2, 8'h02); step(1);
    check("R10 unmasked", int'(irq), 1);

    step(4);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule